// File: doc/BRIEF.md
# Five-Wire Transition-Coded Link Transceiver

This block carries tokens across a point-to-point link built from two groups of five wires, one group for each direction. The two directions work at the same time. Wire levels are never returned to zero. A symbol is one toggle on one of the five wires, so each symbol carries a digit from 0 to 4. A token is sent as four symbols.

On the transmit side a token is either a data byte or a control code. It is taken on a valid/ready handshake and turned into a 9-bit value: a data byte d becomes d, and a control code c becomes 256 + c. That value is sent as four base-5 digits, most significant digit first. Digit k toggles wire k. A runtime setting fixes the minimum number of cycles between two toggles. A setting of 1 gives one toggle per cycle.

On the receive side, each cycle the block compares the incoming wire levels with the levels it held before. It collects one digit for each single-wire change. After four digits it presents the rebuilt token for one cycle. Faults raise a flag that stays set until reset: more than one wire changing in the same cycle, or a rebuilt value that no data byte or control code can produce.

Top module: `tlink5_xcvr`

## Requirements
- R1: After reset, `tx_wires` is 00000, `tx_ready` is 1, `rx_valid` is 0 and `rx_err` is 0. The receiver treats its previous wire levels as 00000.
- R2: Each transmit symbol toggles exactly one bit of `tx_wires`. An accepted token produces exactly four such toggles.
- R3: The token value is `{tx_ctrl, tx_data}`, which is 256*ctrl + data. It is sent as base-5 digits, most significant first. A digit of value k inverts bit k of `tx_wires`.
- R4: Two successive toggles are separated by at least max(`tx_gap`, 1) cycles, and by exactly that many while a token is being sent. A `tx_gap` of 0 behaves as 1.
- R5: A token is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` stays 0 from that edge until the edge of the fourth toggle. The first toggle happens on the edge after acceptance.
- R6: Each cycle in which exactly one bit of `rx_wires` differs from the previous level adds that bit's index as the next digit, most significant first. The cycle after the fourth digit, `rx_valid` is 1 for exactly one cycle. `rx_ctrl` carries bit 8 of the value and `rx_data` carries bits 7:0.
- R7: A cycle in which two or more bits of `rx_wires` change sets `rx_err` and discards any partial token. The next four single-wire changes then form a new token.
- R8: A rebuilt value of 512 or more (the maximum is 624) sets `rx_err` and produces no `rx_valid`.
- R9: `rx_err` stays 1 until reset, and the receiver keeps decoding while it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_gap | input | 4 | Minimum cycles between toggles (0 acts as 1) |
| tx_valid | input | 1 | Transmit token offered |
| tx_ready | output | 1 | Transmitter can take a token |
| tx_ctrl | input | 1 | Transmit token is a control code |
| tx_data | input | 8 | Transmit byte or control code |
| tx_wires | output | 5 | Outgoing transition-coded wire levels |
| rx_wires | input | 5 | Incoming transition-coded wire levels |
| rx_valid | output | 1 | One-cycle pulse on a completed token |
| rx_ctrl | output | 1 | Received token is a control code |
| rx_data | output | 8 | Received byte or control code |
| rx_err | output | 1 | Sticky receive fault flag |

## Verification
A correct transmitter never produces a multi-wire change or a digit pattern of 512 or more, so the receiver's fault paths cannot be reached through loopback. The bench therefore switches the receive wires from the transmit output to its own driven levels. It toggles single wires to leave a half-built token, then flips two wires in one cycle, and after that sends a complete token to show the partial one was discarded. Using the same direct drive, it sends digit patterns for 511 and 512, one on each side of the representable limit, to probe the range check exactly at its edge.

// File: rtl/tlink5_pkg.sv
package tlink5_pkg;
  localparam int WIRES     = 5;
  localparam int SYMS      = 4;
  localparam int TOKW      = 9;
  localparam int ACCW      = 10;
  localparam int DIGW      = $clog2(WIRES);
  localparam int SENT_W    = $clog2(SYMS);
  localparam int TOK_LIMIT = 1 << TOKW;

  function automatic int unsigned pow5(int unsigned e);
    int unsigned p;
    p = 1;
    for (int unsigned i = 0; i < e; i++) p = p * 5;
    return p;
  endfunction

  // digit k of a token, k = 0 is the most significant
  function automatic logic [DIGW-1:0] digit_of(logic [TOKW-1:0] v, int unsigned k);
    int unsigned q;
    q = 32'(v) / pow5(SYMS - 1 - k);
    return DIGW'(q % 5);
  endfunction

  function automatic logic [ACCW-1:0] push_digit(logic [ACCW-1:0] acc, logic [DIGW-1:0] d);
    return ACCW'(32'(acc) * 5 + 32'(d));
  endfunction

  function automatic logic [DIGW-1:0] wire_index(logic [WIRES-1:0] m);
    logic [DIGW-1:0] idx;
    idx = '0;
    for (int i = 0; i < WIRES; i++) if (m[i]) idx = DIGW'(i);
    return idx;
  endfunction
endpackage

// File: rtl/tlink5_tx.sv
module tlink5_tx
  import tlink5_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_cfg,
  input  logic             tok_valid,
  output logic             tok_ready,
  input  logic             tok_ctrl,
  input  logic [7:0]       tok_data,
  output logic [WIRES-1:0] wires
);
  logic              busy;
  logic [SENT_W-1:0] sent;
  logic [GAP_W-1:0]  hold;
  logic [DIGW-1:0]   digs [SYMS];
  logic [GAP_W-1:0]  eff_gap;
  logic              accept, fire, last_fire;
  logic [TOKW-1:0]   tok_val;

  assign tok_val   = {tok_ctrl, tok_data};
  assign eff_gap   = (gap_cfg == '0) ? GAP_W'(1) : gap_cfg;
  assign tok_ready = !busy;
  assign accept    = tok_valid && !busy;
  assign fire      = busy && (hold == '0);
  assign last_fire = fire && (sent == SENT_W'(SYMS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sent  <= '0;
      hold  <= '0;
      wires <= '0;
      for (int k = 0; k < SYMS; k++) digs[k] <= '0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        sent <= '0;
        for (int k = 0; k < SYMS; k++) digs[k] <= digit_of(tok_val, k);
      end
      if (fire) begin
        wires <= wires ^ (WIRES'(1) << digs[sent]);
        sent  <= sent + SENT_W'(1);
        hold  <= eff_gap - GAP_W'(1);
        if (last_fire) busy <= 1'b0;
      end else if (hold != '0) begin
        hold <= hold - GAP_W'(1);
      end
    end
  end

  // ---- checking logic ----
  logic [WIRES-1:0] wires_q;
  logic             toggled;
  logic [3:0]       pend;
  logic [GAP_W:0]   since;
  logic [GAP_W-1:0] gap_at;
  logic             seen;

  assign toggled = (wires != wires_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wires_q <= '0;
      pend    <= '0;
      since   <= '0;
      gap_at  <= '0;
      seen    <= 1'b0;
    end else begin
      wires_q <= wires;
      pend    <= pend - {3'b0, toggled} + (accept ? 4'(SYMS) : 4'd0);
      if (fire) begin
        since  <= (GAP_W+1)'(1);
        gap_at <= eff_gap;
        seen   <= 1'b1;
      end else if (since != '1) begin
        since <= since + (GAP_W+1)'(1);
      end
    end
  end

  assert_one_wire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wires ^ wires_q) <= 1);

  assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen) |-> (since >= {1'b0, gap_at}));

  assert_accept_after_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((pend == 4'd0) || (pend == 4'd1 && toggled)));

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready) |=> !tok_ready);
endmodule

// File: rtl/tlink5_rx.sv
module tlink5_rx
  import tlink5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIRES-1:0] wires,
  output logic             tok_valid,
  output logic             tok_ctrl,
  output logic [7:0]       tok_data,
  output logic             err
);
  logic [WIRES-1:0]  prev;
  logic [ACCW-1:0]   acc;
  logic [SENT_W-1:0] cnt;
  logic [WIRES-1:0]  diff;
  logic              single, multi, complete, bad_val;
  logic [DIGW-1:0]   digit;
  logic [ACCW-1:0]   full;

  assign diff     = wires ^ prev;
  assign single   = ($countones(diff) == 1);
  assign multi    = ($countones(diff) > 1);
  assign digit    = wire_index(diff);
  assign full     = push_digit(acc, digit);
  assign complete = single && (cnt == SENT_W'(SYMS - 1));
  assign bad_val  = complete && (full >= ACCW'(TOK_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= '0;
      acc       <= '0;
      cnt       <= '0;
      tok_valid <= 1'b0;
      tok_ctrl  <= 1'b0;
      tok_data  <= '0;
      err       <= 1'b0;
    end else begin
      prev      <= wires;
      tok_valid <= 1'b0;
      if (multi) begin
        err <= 1'b1;
        acc <= '0;
        cnt <= '0;
      end else if (complete) begin
        acc <= '0;
        cnt <= '0;
        if (bad_val) begin
          err <= 1'b1;
        end else begin
          tok_valid <= 1'b1;
          tok_ctrl  <= full[TOKW-1];
          tok_data  <= full[7:0];
        end
      end else if (single) begin
        acc <= full;
        cnt <= cnt + SENT_W'(1);
      end
    end
  end

  assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> !tok_valid);

  assert_multi_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    multi |=> err);

  assert_range_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_val |=> (err && !tok_valid));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/tlink5_xcvr.sv
module tlink5_xcvr
  import tlink5_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] tx_gap,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             tx_ctrl,
  input  logic [7:0]       tx_data,
  output logic [WIRES-1:0] tx_wires,
  input  logic [WIRES-1:0] rx_wires,
  output logic             rx_valid,
  output logic             rx_ctrl,
  output logic [7:0]       rx_data,
  output logic             rx_err
);
  tlink5_tx #(.GAP_W(GAP_W)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .gap_cfg   (tx_gap),
    .tok_valid (tx_valid),
    .tok_ready (tx_ready),
    .tok_ctrl  (tx_ctrl),
    .tok_data  (tx_data),
    .wires     (tx_wires)
  );

  tlink5_rx i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wires     (rx_wires),
    .tok_valid (rx_valid),
    .tok_ctrl  (rx_ctrl),
    .tok_data  (rx_data),
    .err       (rx_err)
  );
endmodule

// File: tb/test_tlink5_xcvr.sv
module test_tlink5_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_gap = 4'd1;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_ctrl = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [4:0] tx_wires;
  logic [4:0] rx_wires;
  logic       rx_valid, rx_ctrl, rx_err;
  logic [7:0] rx_data;
  logic       loop_on = 1'b1;
  logic [4:0] drv = 5'b0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign rx_wires = loop_on ? tx_wires : drv;

  tlink5_xcvr i_tlink5_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_gap(tx_gap), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_ctrl(tx_ctrl), .tx_data(tx_data),
    .tx_wires(tx_wires), .rx_wires(rx_wires), .rx_valid(rx_valid),
    .rx_ctrl(rx_ctrl), .rx_data(rx_data), .rx_err(rx_err)
  );

  // {ctrl, data, gap}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 8'h00, 4'd1}, {1'b0, 8'hFF, 4'd1}, {1'b1, 8'h00, 4'd2},
    {1'b1, 8'hFF, 4'd3}, {1'b0, 8'h5A, 4'd0}, {1'b0, 8'hA5, 4'd5},
    {1'b1, 8'h3C, 4'd1}, {1'b0, 8'h7E, 4'd4}
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drv = 5'b0;
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx_sym(int w);
    drv[w] = ~drv[w];
    tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(tx_wires == 5'b0, "R1", "tx_wires", tx_wires, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(rx_err == 1'b0, "R1", "rx_err", rx_err, 0);

    // loopback vectors: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      int val, g, tmp, cnt;
      int dg[4];
      logic [4:0] prev, dif;
      val = int'(VEC[v][12:4]);
      g = (VEC[v][3:0] == 0) ? 1 : int'(VEC[v][3:0]);
      tmp = val;
      for (int i = 3; i >= 0; i--) begin
        dg[i] = tmp % 5;
        tmp = tmp / 5;
      end
      tx_ctrl = VEC[v][12];
      tx_data = VEC[v][11:4];
      tx_gap  = VEC[v][3:0];
      tx_valid = 1'b1;
      tick();
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0, "R5", "ready after accept", tx_ready, 0);
      prev = tx_wires;
      for (int j = 0; j < 4; j++) begin
        cnt = 0;
        do begin
          tick();
          cnt++;
        end while (tx_wires == prev && cnt < 40);
        dif = tx_wires ^ prev;
        prev = tx_wires;
        chk($countones(dif) == 1, "R2", "wires toggled", $countones(dif), 1);
        chk(dif == (5'b1 << dg[j]), "R3", "toggle mask", dif, 1 << dg[j]);
        chk(cnt == ((j == 0) ? 1 : g), "R4", "toggle spacing", cnt, (j == 0) ? 1 : g);
        if (j < 3) chk(tx_ready == 1'b0, "R5", "ready mid token", tx_ready, 0);
      end
      chk(tx_ready == 1'b1, "R5", "ready after fourth", tx_ready, 1);
      tick();
      chk(rx_valid == 1'b1, "R6", "rx_valid", rx_valid, 1);
      chk({rx_ctrl, rx_data} == 9'(val), "R6", "rx token", {rx_ctrl, rx_data}, val);
      tick();
      chk(rx_valid == 1'b0, "R6", "rx_valid one cycle", rx_valid, 0);
      chk(tx_wires == prev, "R2", "no extra toggle", tx_wires, prev);
      repeat (6) tick();
    end

    // direct receive drive
    do_reset();
    loop_on = 1'b0;
    rx_sym(2);
    rx_sym(1);
    drv = drv ^ 5'b00011;
    tick();
    chk(rx_err == 1'b1, "R7", "err on double change", rx_err, 1);
    // 3,0,1,2 -> 382 : ctrl 1, data 126
    rx_sym(3); rx_sym(0); rx_sym(1);
    chk(rx_valid == 1'b0, "R7", "no early valid", rx_valid, 0);
    rx_sym(2);
    chk(rx_valid == 1'b1, "R7", "fresh token after discard", rx_valid, 1);
    chk({rx_ctrl, rx_data} == 9'd382, "R7", "fresh token value", {rx_ctrl, rx_data}, 382);
    chk(rx_err == 1'b1, "R9", "err sticky while decoding", rx_err, 1);
    repeat (3) tick();
    chk(rx_err == 1'b1, "R9", "err still set", rx_err, 1);

    do_reset();
    chk(rx_err == 1'b0, "R1", "err cleared by reset", rx_err, 0);
    // 4,0,2,1 -> 511
    rx_sym(4); rx_sym(0); rx_sym(2); rx_sym(1);
    chk(rx_valid == 1'b1, "R8", "511 accepted", rx_valid, 1);
    chk({rx_ctrl, rx_data} == 9'd511, "R8", "511 value", {rx_ctrl, rx_data}, 511);
    chk(rx_err == 1'b0, "R8", "511 no err", rx_err, 0);
    // 4,0,2,2 -> 512
    rx_sym(4); rx_sym(0); rx_sym(2); rx_sym(2);
    chk(rx_valid == 1'b0, "R8", "512 no valid", rx_valid, 0);
    chk(rx_err == 1'b1, "R8", "512 flags err", rx_err, 1);
    do_reset();
    // 4,4,4,4 -> 624
    rx_sym(4); rx_sym(4); rx_sym(4); rx_sym(4);
    chk(rx_valid == 1'b0, "R8", "624 no valid", rx_valid, 0);
    chk(rx_err == 1'b1, "R8", "624 flags err", rx_err, 1);

    summary();
  end
endmodule